// File: doc/BRIEF.md
# NOR Flash Command Sequence Decoder

This block watches the write cycles that a host sends to a parallel NOR flash in 16-bit mode. It recognises the two-write unlock prefix and the command byte that follows it, and it also recognises the short single-write commands. From these it keeps track of which mode the device is in: normal array reads, identification reads, the shortened-program (bypass) mode, the one-time secured region, the query table and reads while an erase is suspended.

When a sequence is complete, the block raises a one-clock request toward the embedded algorithm engine: program, chip erase, sector erase, suspend or resume. The request carries the address and data of the write that finished the sequence. A registered read-select code tells the read datapath which source to return, such as array data, an ID word, the protection status, a query word or a secured-region word. The block checks suspend requests against an `erase_running` flag from the algorithm engine. It tracks the suspended state itself.

Top module: `nor_cmd_decoder`

## Requirements
- R1: After synchronous reset, `mode` is 0 (read array), `rd_sel` is 0 (array) and no request output is high.
- R2: The first unlock write is data AA at address 555h and the second is data 55 at address 2AAh. The command byte then follows at 555h. Only address bits [11:0] and data bits [7:0] are compared, so all higher bits are ignored.
- R3: Unlock followed by 90h sets `mode` to 1 (autoselect). The next `rd_sel` is then picked from the low byte of `rd_addr`: offset 00h gives 1 (maker ID), 01h gives 2, 0Eh gives 3, 0Fh gives 4 (device ID words), 02h gives 5 (group protection, with the upper sector bits ignored), and any other offset gives 0.
- R4: Unlock followed by A0h arms a program. The next write raises `req_program`, and `req_addr`/`req_data` hold that write's full address and data.
- R5: Unlock, 80h, AA at 555h and 55 at 2AAh arm an erase. A following 10h at 555h raises `req_chip_erase`. A following 30h at any address raises `req_sector_erase`, and `req_addr` holds that address.
- R6: A write of F0h returns `mode` to 0, or to 5 (erase-suspend read) while an erase is suspended. F0h works as a single write and also as the command byte after an unlock.
- R7: A single write of B0h raises `req_suspend` and sets `mode` to 5, but only while `erase_running` is high and no erase is already suspended. A single write of 30h raises `req_resume` and sets `mode` to 0, but only while suspended. Otherwise both writes are ignored.
- R8: A write of 98h at address 55h sets `mode` to 4 (query) and `rd_sel` to 6. It is accepted only from mode 0 or 1 and is ignored in every other mode.
- R9: Unlock followed by 20h from mode 0 sets `mode` to 2 (bypass). In bypass, A0h followed by one write raises `req_program`, and 90h followed by 00h returns `mode` to 0. Every other write in bypass is ignored, including unlock writes and F0h.
- R10: Unlock followed by 88h from mode 0 sets `mode` to 3 (secured region), and `rd_sel` becomes 7. In that mode, unlock, 90h and then 00h return `mode` to 0.
- R11: A write that does not match the expected next cycle drops the partial sequence and leaves `mode` unchanged. The mismatching write is not taken as the start of a new sequence.
- R12: Requests are registered. A request rises in the clock after the edge that sampled the completing write, stays high for exactly one clock, and at most one request is high at a time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_stb | input | 1 | One-clock write strobe; address and data are sampled with it |
| wr_addr | input | ADDR_W | Word address of the write |
| wr_data | input | 16 | Write data |
| erase_running | input | 1 | High while the algorithm engine runs a sector erase |
| rd_addr | input | RD_OFS_W | Low bits of the current read address |
| req_program | output | 1 | One-clock program request |
| req_chip_erase | output | 1 | One-clock chip erase request |
| req_sector_erase | output | 1 | One-clock sector erase request |
| req_suspend | output | 1 | One-clock erase suspend request |
| req_resume | output | 1 | One-clock erase resume request |
| req_addr | output | ADDR_W | Address latched with the request |
| req_data | output | 16 | Data latched with the request |
| mode | output | 3 | Current mode code (0..5) |
| rd_sel | output | 3 | Read datapath select code (0..7) |

## Verification
The hardest state to reach is the erase-suspend context. To get there, the bench raises `erase_running` as if an erase were in progress, sends the single-write suspend, and then enters autoselect. It then checks that the reset write lands in erase-suspend read rather than read array. A suspend attempt with `erase_running` low, a second suspend while already suspended, and a resume without a pending suspend are all checked to raise no request. The bypass mode is driven with full unlock prefixes and query writes to confirm that they are swallowed there.

// File: rtl/nor_cmd_pkg.sv
package nor_cmd_pkg;

  localparam int CMD_W = 8;

  typedef enum logic [2:0] {
    MD_READ = 3'd0,
    MD_AUTO = 3'd1,
    MD_BYP  = 3'd2,
    MD_SEC  = 3'd3,
    MD_CFI  = 3'd4,
    MD_ESR  = 3'd5
  } mode_e;

  typedef enum logic [3:0] {
    SQ_IDLE,
    SQ_UL1,
    SQ_UL2,
    SQ_PROG,
    SQ_ER3,
    SQ_ER4,
    SQ_ER5,
    SQ_BPROG,
    SQ_BEXIT,
    SQ_SEXIT
  } seq_e;

  typedef enum logic [2:0] {
    RS_ARRAY = 3'd0,
    RS_MFR   = 3'd1,
    RS_DEV1  = 3'd2,
    RS_DEV2  = 3'd3,
    RS_DEV3  = 3'd4,
    RS_PROT  = 3'd5,
    RS_CFI   = 3'd6,
    RS_SEC   = 3'd7
  } rsel_e;

  localparam logic [CMD_W-1:0] C_UNLK1  = 8'hAA;
  localparam logic [CMD_W-1:0] C_UNLK2  = 8'h55;
  localparam logic [CMD_W-1:0] C_AUTO   = 8'h90;
  localparam logic [CMD_W-1:0] C_PROG   = 8'hA0;
  localparam logic [CMD_W-1:0] C_ERASE  = 8'h80;
  localparam logic [CMD_W-1:0] C_CHIP   = 8'h10;
  localparam logic [CMD_W-1:0] C_SECT   = 8'h30;
  localparam logic [CMD_W-1:0] C_BYPASS = 8'h20;
  localparam logic [CMD_W-1:0] C_SECREG = 8'h88;
  localparam logic [CMD_W-1:0] C_RESET  = 8'hF0;
  localparam logic [CMD_W-1:0] C_SUSP   = 8'hB0;
  localparam logic [CMD_W-1:0] C_CFI    = 8'h98;
  localparam logic [CMD_W-1:0] C_ZERO   = 8'h00;

endpackage

// File: rtl/nor_cmd_match.sv
module nor_cmd_match
  import nor_cmd_pkg::*;
#(
  parameter int CMP_AW = 12
) (
  input  logic [CMP_AW-1:0] addr_lo,
  input  logic [CMD_W-1:0]  data_lo,
  output logic              at_555,
  output logic              at_2aa,
  output logic              at_055,
  output logic [CMD_W-1:0]  code
);

  localparam logic [CMP_AW-1:0] A_555 = CMP_AW'(12'h555);
  localparam logic [CMP_AW-1:0] A_2AA = CMP_AW'(12'h2AA);
  localparam logic [CMP_AW-1:0] A_055 = CMP_AW'(12'h055);

  always_comb begin
    at_555 = (addr_lo == A_555);
    at_2aa = (addr_lo == A_2AA);
    at_055 = (addr_lo == A_055);
    code   = data_lo;
  end

endmodule

// File: rtl/nor_seq_fsm.sv
module nor_seq_fsm
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W = 22,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_stb,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              erase_running,
  input  logic              at_555,
  input  logic              at_2aa,
  input  logic              at_055,
  input  logic [CMD_W-1:0]  code,
  output logic              req_program,
  output logic              req_chip_erase,
  output logic              req_sector_erase,
  output logic              req_suspend,
  output logic              req_resume,
  output logic [ADDR_W-1:0] req_addr,
  output logic [DATA_W-1:0] req_data,
  output logic [2:0]        mode
);

  seq_e  seq_q;
  mode_e mode_q;
  logic  susp_q;

  assign mode = mode_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      seq_q            <= SQ_IDLE;
      mode_q           <= MD_READ;
      susp_q           <= 1'b0;
      req_program      <= 1'b0;
      req_chip_erase   <= 1'b0;
      req_sector_erase <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
      req_addr         <= '0;
      req_data         <= '0;
    end else begin
      req_program      <= 1'b0;
      req_chip_erase   <= 1'b0;
      req_sector_erase <= 1'b0;
      req_suspend      <= 1'b0;
      req_resume       <= 1'b0;
      if (wr_stb) begin
        seq_q <= SQ_IDLE;
        case (seq_q)
          SQ_IDLE: begin
            if (mode_q == MD_BYP) begin
              if (code == C_PROG)      seq_q <= SQ_BPROG;
              else if (code == C_AUTO) seq_q <= SQ_BEXIT;
            end else if (code == C_RESET) begin
              mode_q <= susp_q ? MD_ESR : MD_READ;
            end else if (code == C_SUSP) begin
              if (erase_running && !susp_q) begin
                susp_q      <= 1'b1;
                mode_q      <= MD_ESR;
                req_suspend <= 1'b1;
                req_addr    <= wr_addr;
                req_data    <= wr_data;
              end
            end else if (code == C_SECT) begin
              if (susp_q) begin
                susp_q     <= 1'b0;
                mode_q     <= MD_READ;
                req_resume <= 1'b1;
                req_addr   <= wr_addr;
                req_data   <= wr_data;
              end
            end else if (code == C_CFI && at_055) begin
              if (mode_q == MD_READ || mode_q == MD_AUTO) mode_q <= MD_CFI;
            end else if (code == C_UNLK1 && at_555 && mode_q != MD_CFI) begin
              seq_q <= SQ_UL1;
            end
          end
          SQ_UL1: if (code == C_UNLK2 && at_2aa) seq_q <= SQ_UL2;
          SQ_UL2: begin
            if (at_555) begin
              case (code)
                C_AUTO: begin
                  if (mode_q == MD_SEC) seq_q <= SQ_SEXIT;
                  else                  mode_q <= MD_AUTO;
                end
                C_PROG:   seq_q <= SQ_PROG;
                C_ERASE:  if (!susp_q) seq_q <= SQ_ER3;
                C_BYPASS: if (mode_q == MD_READ) mode_q <= MD_BYP;
                C_SECREG: if (mode_q == MD_READ) mode_q <= MD_SEC;
                C_RESET:  mode_q <= susp_q ? MD_ESR : MD_READ;
                default:  ;
              endcase
            end
          end
          SQ_PROG, SQ_BPROG: begin
            req_program <= 1'b1;
            req_addr    <= wr_addr;
            req_data    <= wr_data;
          end
          SQ_ER3: if (code == C_UNLK1 && at_555) seq_q <= SQ_ER4;
          SQ_ER4: if (code == C_UNLK2 && at_2aa) seq_q <= SQ_ER5;
          SQ_ER5: begin
            if (code == C_CHIP && at_555) begin
              req_chip_erase <= 1'b1;
              req_addr       <= wr_addr;
              req_data       <= wr_data;
            end else if (code == C_SECT) begin
              req_sector_erase <= 1'b1;
              req_addr         <= wr_addr;
              req_data         <= wr_data;
            end
          end
          SQ_BEXIT, SQ_SEXIT: if (code == C_ZERO) mode_q <= MD_READ;
          default: ;
        endcase
      end
    end
  end

  // R12
  req_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0({req_program, req_chip_erase, req_sector_erase, req_suspend, req_resume}));

  // R12
  req_needs_write_chk: assert property (@(posedge clk) disable iff (rst)
    (req_program || req_chip_erase || req_sector_erase || req_suspend || req_resume)
      |-> $past(wr_stb));

  // R12
  req_prog_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    req_program |=> !req_program);

  // R7
  susp_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_suspend |-> ($past(erase_running) && !$past(susp_q)));

  // R7
  resume_gate_chk: assert property (@(posedge clk) disable iff (rst)
    req_resume |-> $past(susp_q));

  // R8
  cfi_entry_chk: assert property (@(posedge clk) disable iff (rst)
    (mode_q == MD_CFI && $past(mode_q) != MD_CFI)
      |-> ($past(mode_q) == MD_READ || $past(mode_q) == MD_AUTO));

endmodule

// File: rtl/nor_rd_select.sv
module nor_rd_select
  import nor_cmd_pkg::*;
#(
  parameter int RD_OFS_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [2:0]          mode,
  input  logic [RD_OFS_W-1:0] rd_addr,
  output logic [2:0]          rd_sel
);

  localparam logic [RD_OFS_W-1:0] O_MFR  = RD_OFS_W'(8'h00);
  localparam logic [RD_OFS_W-1:0] O_DEV1 = RD_OFS_W'(8'h01);
  localparam logic [RD_OFS_W-1:0] O_PROT = RD_OFS_W'(8'h02);
  localparam logic [RD_OFS_W-1:0] O_DEV2 = RD_OFS_W'(8'h0E);
  localparam logic [RD_OFS_W-1:0] O_DEV3 = RD_OFS_W'(8'h0F);

  rsel_e sel_d;

  always_comb begin
    sel_d = RS_ARRAY;
    case (mode_e'(mode))
      MD_AUTO: begin
        case (rd_addr)
          O_MFR:   sel_d = RS_MFR;
          O_DEV1:  sel_d = RS_DEV1;
          O_PROT:  sel_d = RS_PROT;
          O_DEV2:  sel_d = RS_DEV2;
          O_DEV3:  sel_d = RS_DEV3;
          default: sel_d = RS_ARRAY;
        endcase
      end
      MD_CFI:  sel_d = RS_CFI;
      MD_SEC:  sel_d = RS_SEC;
      default: sel_d = RS_ARRAY;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) rd_sel <= RS_ARRAY;
    else     rd_sel <= sel_d;
  end

  // R8
  cfi_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RS_CFI) |-> ($past(mode) == MD_CFI));

  // R3
  id_sel_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_sel == RS_MFR || rd_sel == RS_PROT) |-> ($past(mode) == MD_AUTO));

endmodule

// File: rtl/nor_cmd_decoder.sv
module nor_cmd_decoder
  import nor_cmd_pkg::*;
#(
  parameter int ADDR_W   = 22,
  parameter int DATA_W   = 16,
  parameter int CMP_AW   = 12,
  parameter int RD_OFS_W = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_stb,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [DATA_W-1:0]   wr_data,
  input  logic                erase_running,
  input  logic [RD_OFS_W-1:0] rd_addr,
  output logic                req_program,
  output logic                req_chip_erase,
  output logic                req_sector_erase,
  output logic                req_suspend,
  output logic                req_resume,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [DATA_W-1:0]   req_data,
  output logic [2:0]          mode,
  output logic [2:0]          rd_sel
);

  logic             at_555, at_2aa, at_055;
  logic [CMD_W-1:0] code;

  nor_cmd_match #(.CMP_AW(CMP_AW)) u_match (
    .addr_lo (wr_addr[CMP_AW-1:0]),
    .data_lo (wr_data[CMD_W-1:0]),
    .at_555  (at_555),
    .at_2aa  (at_2aa),
    .at_055  (at_055),
    .code    (code)
  );

  nor_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
    .clk              (clk),
    .rst              (rst),
    .wr_stb           (wr_stb),
    .wr_addr          (wr_addr),
    .wr_data          (wr_data),
    .erase_running    (erase_running),
    .at_555           (at_555),
    .at_2aa           (at_2aa),
    .at_055           (at_055),
    .code             (code),
    .req_program      (req_program),
    .req_chip_erase   (req_chip_erase),
    .req_sector_erase (req_sector_erase),
    .req_suspend      (req_suspend),
    .req_resume       (req_resume),
    .req_addr         (req_addr),
    .req_data         (req_data),
    .mode             (mode)
  );

  nor_rd_select #(.RD_OFS_W(RD_OFS_W)) u_rdsel (
    .clk     (clk),
    .rst     (rst),
    .mode    (mode),
    .rd_addr (rd_addr),
    .rd_sel  (rd_sel)
  );

endmodule

// File: tb/nor_cmd_decoder_bench.sv
module nor_cmd_decoder_bench;

  localparam int AW = 22;
  localparam logic [2:0] M_READ = 3'd0, M_AUTO = 3'd1, M_BYP = 3'd2,
                         M_SEC = 3'd3, M_CFI = 3'd4, M_ESR = 3'd5;
  localparam logic [4:0] Q_NONE = 5'b00000, Q_PROG = 5'b10000, Q_CHIP = 5'b01000,
                         Q_SECT = 5'b00100, Q_SUSP = 5'b00010, Q_RESM = 5'b00001;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_stb = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [15:0]   wr_data = '0;
  logic          erase_running = 1'b0;
  logic [7:0]    rd_addr = '0;
  logic          req_program, req_chip_erase, req_sector_erase, req_suspend, req_resume;
  logic [AW-1:0] req_addr;
  logic [15:0]   req_data;
  logic [2:0]    mode, rd_sel;

  int tests = 0;
  int fails = 0;
  bit done  = 1'b0;

  typedef struct {
    logic [4:0]    req;
    logic [AW-1:0] a;
    logic [15:0]   d;
    logic [2:0]    md;
    string         tag;
  } exp_t;

  exp_t exp_q[$];

  always #5 clk = ~clk;

  nor_cmd_decoder u_nor_cmd_decoder (
    .clk, .rst, .wr_stb, .wr_addr, .wr_data, .erase_running, .rd_addr,
    .req_program, .req_chip_erase, .req_sector_erase, .req_suspend, .req_resume,
    .req_addr, .req_data, .mode, .rd_sel
  );

  wire [4:0] got_req = {req_program, req_chip_erase, req_sector_erase, req_suspend, req_resume};

  // Driver: one strobed write, expected result queued for the monitor.
  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d,
                    input logic [4:0] er, input logic [2:0] em, input string tag);
    exp_t e;
    e.req = er; e.a = a; e.d = d; e.md = em; e.tag = tag;
    @(negedge clk);
    wr_addr = a; wr_data = d; wr_stb = 1'b1;
    exp_q.push_back(e);
    @(negedge clk);
    wr_stb = 1'b0;
  endtask

  // R2: unlock prefix with junk in the ignored upper address and data bits
  task automatic unlock(input logic [2:0] em);
    wr(22'h1F5555, 16'hC3AA, Q_NONE, em, "R2");
    wr(22'h0C32AA, 16'h7755, Q_NONE, em, "R2");
  endtask

  task automatic chk_sel(input logic [7:0] a, input logic [2:0] ex, input string tag);
    @(negedge clk);
    rd_addr = a;
    @(negedge clk);
    tests++;
    if (rd_sel !== ex) begin
      fails++;
      $display("FAIL %s rd_sel offset %h: got %0d expected %0d", tag, a, rd_sel, ex);
    end
  endtask

  // Monitor: compares each write's result one clock after its sampling edge.
  logic mon_s;
  always @(posedge clk) begin
    mon_s = wr_stb;
    #2;
    if (!rst && !done) begin
      if (mon_s) begin
        tests++;
        if (exp_q.size() == 0) begin
          fails++;
          $display("FAIL R12 unexpected result: got req %b expected none queued", got_req);
        end else begin
          exp_t e;
          e = exp_q.pop_front();
          if (got_req !== e.req || mode !== e.md ||
              (e.req != 0 && (req_addr !== e.a || req_data !== e.d))) begin
            fails++;
            $display("FAIL %s req/mode/addr/data: got %b/%0d/%h/%h expected %b/%0d/%h/%h",
                     e.tag, got_req, mode, req_addr, req_data, e.req, e.md, e.a, e.d);
          end
        end
      end else begin
        tests++;
        if (got_req !== Q_NONE) begin
          fails++;
          $display("FAIL R12 request outside a write slot: got %b expected %b", got_req, Q_NONE);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog expired: got hang expected finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1 reset state
    tests++;
    if (mode !== M_READ || rd_sel !== 3'd0 || got_req !== Q_NONE) begin
      fails++;
      $display("FAIL R1 reset: got mode %0d sel %0d req %b expected 0 0 00000", mode, rd_sel, got_req);
    end
    rst = 1'b0;

    // R3 autoselect and ID selects
    unlock(M_READ);
    wr(22'h2A0555, 16'h1290, Q_NONE, M_AUTO, "R3");
    chk_sel(8'h00, 3'd1, "R3");
    chk_sel(8'h01, 3'd2, "R3");
    chk_sel(8'h0E, 3'd3, "R3");
    chk_sel(8'h0F, 3'd4, "R3");
    chk_sel(8'h02, 3'd5, "R3");
    chk_sel(8'h05, 3'd0, "R3");

    // R8 query from autoselect, R6 single-write reset
    wr(22'h000055, 16'h0098, Q_NONE, M_CFI, "R8");
    chk_sel(8'h10, 3'd6, "R8");
    wr(22'h000000, 16'h00F0, Q_NONE, M_READ, "R6");

    // R4 program
    unlock(M_READ);
    wr(22'h000555, 16'h00A0, Q_NONE, M_READ, "R4");
    wr(22'h012345, 16'hBEEF, Q_PROG, M_READ, "R4");

    // R11 aborts
    wr(22'h000555, 16'h00AA, Q_NONE, M_READ, "R11");
    wr(22'h0002AB, 16'h0055, Q_NONE, M_READ, "R11");
    wr(22'h000555, 16'h0090, Q_NONE, M_READ, "R11");
    unlock(M_READ);
    wr(22'h000555, 16'h0077, Q_NONE, M_READ, "R11");
    wr(22'h000100, 16'h1234, Q_NONE, M_READ, "R11");

    // R5 chip erase then sector erase
    unlock(M_READ);
    wr(22'h000555, 16'h0080, Q_NONE, M_READ, "R5");
    unlock(M_READ);
    wr(22'h1F5555, 16'h0010, Q_CHIP, M_READ, "R5");
    unlock(M_READ);
    wr(22'h000555, 16'h0080, Q_NONE, M_READ, "R5");
    unlock(M_READ);
    wr(22'h02A000, 16'h0030, Q_SECT, M_READ, "R5");

    // R7 suspend and resume gating, R6 reset while suspended
    wr(22'h000000, 16'h00B0, Q_NONE, M_READ, "R7");
    erase_running = 1'b1;
    wr(22'h000777, 16'h00B0, Q_SUSP, M_ESR, "R7");
    wr(22'h000777, 16'h00B0, Q_NONE, M_ESR, "R7");
    unlock(M_ESR);
    wr(22'h000555, 16'h0090, Q_NONE, M_AUTO, "R6");
    wr(22'h000000, 16'h00F0, Q_NONE, M_ESR, "R6");
    wr(22'h000000, 16'h0030, Q_RESM, M_READ, "R7");
    wr(22'h000000, 16'h0030, Q_NONE, M_READ, "R7");
    erase_running = 1'b0;

    // R9 bypass mode, R8 query ignored there
    unlock(M_READ);
    wr(22'h000555, 16'h0020, Q_NONE, M_BYP, "R9");
    wr(22'h000055, 16'h0098, Q_NONE, M_BYP, "R8");
    wr(22'h000555, 16'h00AA, Q_NONE, M_BYP, "R9");
    wr(22'h000000, 16'h00F0, Q_NONE, M_BYP, "R9");
    wr(22'h000000, 16'h00A0, Q_NONE, M_BYP, "R9");
    wr(22'h00ABCD, 16'h5A5A, Q_PROG, M_BYP, "R9");
    wr(22'h000000, 16'h0090, Q_NONE, M_BYP, "R9");
    wr(22'h000000, 16'h0000, Q_NONE, M_READ, "R9");

    // R10 secured region entry and exit
    unlock(M_READ);
    wr(22'h000555, 16'h0088, Q_NONE, M_SEC, "R10");
    chk_sel(8'h20, 3'd7, "R10");
    wr(22'h000055, 16'h0098, Q_NONE, M_SEC, "R8");
    unlock(M_SEC);
    wr(22'h000555, 16'h0090, Q_NONE, M_SEC, "R10");
    wr(22'h000000, 16'h0000, Q_NONE, M_READ, "R10");
    chk_sel(8'h20, 3'd0, "R10");

    repeat (4) @(negedge clk);
    tests++;
    if (exp_q.size() != 0) begin
      fails++;
      $display("FAIL R12 pending results: got %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule